// File: doc/BRIEF.md
# UART Receive Interrupt Status

This block builds the raw and masked interrupt status words of a UART receiver. It sits between the receive deserializer, the receive FIFO and the register bank. The deserializer reports each finished character with its data, its received parity bit and its stop bit, plus a separate strobe when it sees a line break. The FIFO reports its full and empty flags and each push. From these inputs the block decides which error and event conditions have occurred, holds them until software clears them, and gates them with a mask to drive one interrupt line.

The parity check happens here. The expected parity bit comes from the even/odd and stick settings, and the received bit is compared against it. A receive-timeout detector counts bit-period ticks while the FIFO holds data and no new character arrives. Its status bit follows rules of its own. The mask bit acts as its enable. It drops by itself when the FIFO drains, and a clear write restarts its count.

Top module: `uart_rx_irq_status`

## Requirements
- R1: Status word layout: bit 10 overrun, bit 9 break, bit 8 parity, bit 7 framing, bit 6 receive timeout, bit 5 transmit event, bit 4 receive event. Every other bit of the 32-bit word reads 0, and after reset the whole word is 0.
- R2: A character completing (`char_done`=1) while `fifo_full`=1 sets the overrun bit at the next clock edge.
- R3: A character completing with `char_stop_bit`=0 sets the framing bit at the next clock edge. A stop bit of 1 leaves the framing bit alone.
- R4: With `par_en`=1, a character whose `char_par_bit` differs from the expected bit sets the parity bit. The expected bit is as follows. With `par_stick`=1 it is 0 when `par_even`=1 and 1 when `par_even`=0. With `par_stick`=0 it is the XOR of the data bits when `par_even`=1, and the inverse of that XOR when `par_even`=0. With `par_en`=0 the parity bit is never set.
- R5: A pulse on `brk_det` sets the break bit at the next edge.
- R6: Every bit except the timeout bit stays set until a write with `clr_wr`=1 carries a 1 at its position in `clr_data`. A 0 in `clr_data` leaves the bit unchanged. When a set and a clear hit the same bit in the same cycle, the set wins. `tx_evt` and `rx_evt` set bits 5 and 4 under the same rules.
- R7: The timeout counter restarts on a FIFO push, while the FIFO is empty, and on a timeout clear. It advances once per `bit_tick` while the FIFO is not empty. The timeout bit rises one cycle after the counter reaches TO_BITS (32) ticks.
- R8: The timeout bit is 0 one cycle after `fifo_empty` is 1, and one cycle after a clear write with bit 6 set.
- R9: The timeout bit can only be 1 while `irq_mask[6]`=1, so its raw and masked values are always equal.
- R10: `masked_stat` equals `raw_stat` AND `irq_mask`, combinationally. `irq` is the OR of all bits of `masked_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | One-cycle strobe: a character has been received |
| char_data | input | 8 | Data bits of that character |
| char_par_bit | input | 1 | Parity bit received with that character |
| char_stop_bit | input | 1 | Stop bit received with that character |
| par_en | input | 1 | Parity checking enable |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| par_stick | input | 1 | 1 selects stick (fixed) parity |
| brk_det | input | 1 | Strobe: line held low longer than a character time |
| tx_evt | input | 1 | Strobe: transmit event |
| rx_evt | input | 1 | Strobe: receive event |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_empty | input | 1 | Receive FIFO empty |
| fifo_push | input | 1 | Strobe: a character written into the FIFO |
| bit_tick | input | 1 | One pulse per bit period |
| irq_mask | input | 11 | Mask, same bit layout as the status word |
| clr_wr | input | 1 | Clear write strobe |
| clr_data | input | 11 | Clear write data, 1 clears the bit at that position |
| raw_stat | output | 32 | Raw status word |
| masked_stat | output | 32 | Raw status AND mask |
| irq | output | 1 | OR of masked status |

## Verification
The hardest state to reach from the ports is the exact edge at which the timeout fires. The bench pushes a character and then delivers exactly 31 and then 32 bit ticks, checking the bit on each side of the threshold. The same run is repeated with the mask off, with a push in the middle of the count, and after a clear write, to show that each of these restarts or blocks the count. The parity compare is swept over every data byte, both received parity values and all four parity modes. The mask is swept over all 2048 values with every sticky bit set.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int STAT_W = 11;
    localparam int WORD_W = 32;
    localparam int OVR_B  = 10;
    localparam int BRK_B  = 9;
    localparam int PAR_B  = 8;
    localparam int FE_B   = 7;
    localparam int RT_B   = 6;
    localparam int TX_B   = 5;
    localparam int RX_B   = 4;
    localparam int LOW_W  = 4;
endpackage

// File: rtl/uart_par_check.sv
module uart_par_check #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              rx_bit,
    input  logic              en,
    input  logic              even,
    input  logic              stick,
    output logic              mismatch
);
    logic xor_all;
    logic want;

    always_comb begin
        xor_all = ^data;
        if (stick) begin
            want = ~even;
        end else if (even) begin
            want = xor_all;
        end else begin
            want = ~xor_all;
        end
        mismatch = en & (want ^ rx_bit);
    end
endmodule

// File: rtl/uart_rto_timer.sv
module uart_rto_timer #(
    parameter int TO_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(TO_BITS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TO_BITS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt != LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.cnt == LIMIT);
endmodule

// File: rtl/uart_evt_latch.sv
module uart_evt_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    logic [N-1:0] bit_d, bit_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            if (set[g]) begin
                bit_d[g] = 1'b1;
            end else if (clr[g]) begin
                bit_d[g] = 1'b0;
            end else begin
                bit_d[g] = bit_q[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign q = bit_q;
endmodule

// File: rtl/uart_rx_irq_status.sv
module uart_rx_irq_status
    import uart_irq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TO_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_par_bit,
    input  logic              char_stop_bit,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              brk_det,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              fifo_push,
    input  logic              bit_tick,
    input  logic [STAT_W-1:0] irq_mask,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_data,
    output logic [WORD_W-1:0] raw_stat,
    output logic [WORD_W-1:0] masked_stat,
    output logic              irq
);
    localparam int NSTK = 6;

    typedef struct packed {
        logic rt;
    } rt_t;

    logic            par_bad;
    logic            expired;
    logic            clr_rt;
    logic            restart;
    logic [NSTK-1:0] stk_set, stk_clr, stk_q;
    rt_t             rt_d, rt_q;
    logic [STAT_W-1:0] stat;

    uart_par_check #(.DATA_W(DATA_W)) u_par (
        .data     (char_data),
        .rx_bit   (char_par_bit),
        .en       (par_en),
        .even     (par_even),
        .stick    (par_stick),
        .mismatch (par_bad)
    );

    // sticky order: ovr, brk, par, fe, tx, rx
    always_comb begin
        stk_set = {char_done & fifo_full,
                   brk_det,
                   char_done & par_bad,
                   char_done & ~char_stop_bit,
                   tx_evt,
                   rx_evt};
        stk_clr = {NSTK{clr_wr}} & {clr_data[OVR_B], clr_data[BRK_B],
                                    clr_data[PAR_B], clr_data[FE_B],
                                    clr_data[TX_B],  clr_data[RX_B]};
    end

    uart_evt_latch #(.N(NSTK)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stk_set),
        .clr   (stk_clr),
        .q     (stk_q)
    );

    assign clr_rt  = clr_wr & clr_data[RT_B];
    assign restart = fifo_push | fifo_empty | clr_rt;

    uart_rto_timer #(.TO_BITS(TO_BITS)) u_rto (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (bit_tick),
        .expired (expired)
    );

    always_comb begin
        rt_d    = rt_q;
        rt_d.rt = ~fifo_empty & ~clr_rt & irq_mask[RT_B] & (rt_q.rt | expired);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    always_comb begin
        stat        = '0;
        stat[OVR_B] = stk_q[5];
        stat[BRK_B] = stk_q[4];
        stat[PAR_B] = stk_q[3];
        stat[FE_B]  = stk_q[2];
        stat[RT_B]  = rt_q.rt & irq_mask[RT_B];
        stat[TX_B]  = stk_q[1];
        stat[RX_B]  = stk_q[0];
        raw_stat    = {{(WORD_W-STAT_W){1'b0}}, stat};
        masked_stat = {{(WORD_W-STAT_W){1'b0}}, stat & irq_mask};
        irq         = |masked_stat;
    end
endmodule

// File: rtl/uart_rx_irq_chk.sv
module uart_rx_irq_chk
    import uart_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              char_done,
    input logic              char_stop_bit,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              brk_det,
    input logic [STAT_W-1:0] irq_mask,
    input logic              clr_wr,
    input logic [STAT_W-1:0] clr_data,
    input logic [WORD_W-1:0] raw_stat
);
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && fifo_full) |=> raw_stat[OVR_B]); // R2
    AST_FE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !char_stop_bit) |=> raw_stat[FE_B]); // R3
    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det |=> raw_stat[BRK_B]); // R5
    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[BRK_B] && !(clr_wr && clr_data[BRK_B])) |=> raw_stat[BRK_B]); // R6
    AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[OVR_B] && !(char_done && fifo_full)) |=> !raw_stat[OVR_B]); // R6
    AST_RT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |=> !raw_stat[RT_B]); // R8
    AST_RT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[RT_B]) |=> !raw_stat[RT_B]); // R8
    AST_RT_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_stat[RT_B]) |-> irq_mask[RT_B]); // R9
endmodule

bind uart_rx_irq_status uart_rx_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_done     (char_done),
    .char_stop_bit (char_stop_bit),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .brk_det       (brk_det),
    .irq_mask      (irq_mask),
    .clr_wr        (clr_wr),
    .clr_data      (clr_data),
    .raw_stat      (raw_stat)
);

// File: tb/uart_rx_irq_status_test.sv
module uart_rx_irq_status_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_done = 0, char_par_bit = 0, char_stop_bit = 1;
    logic [7:0]  char_data = '0;
    logic        par_en = 0, par_even = 0, par_stick = 0;
    logic        brk_det = 0, tx_evt = 0, rx_evt = 0;
    logic        fifo_full = 0, fifo_empty = 1, fifo_push = 0, bit_tick = 0;
    logic [10:0] irq_mask = '0;
    logic        clr_wr = 0;
    logic [10:0] clr_data = '0;
    logic [31:0] raw_stat, masked_stat;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_irq_status uut (.*);

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear(input logic [10:0] bits);
        clr_wr = 1; clr_data = bits;
        cyc();
        clr_wr = 0; clr_data = '0;
    endtask

    task automatic send(input logic [7:0] d, input logic pb, input logic stop);
        char_data = d; char_par_bit = pb; char_stop_bit = stop; char_done = 1;
        cyc();
        char_done = 0; char_stop_bit = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk(raw_stat, 0, "R1 reset raw");
        chk({masked_stat[30:0], irq}, 0, "R1 reset masked/irq");
        rst_n = 1;
        cyc();

        // R3 framing
        send(8'h00, 0, 1);
        chk(raw_stat, 0, "R3 good stop no flag");
        send(8'h00, 0, 0);
        chk(raw_stat, 32'h80, "R3 framing set");
        // R6 write 0 no effect
        clear(11'h000);
        chk(raw_stat, 32'h80, "R6 zero write ignored");
        clear(11'h080);
        chk(raw_stat, 0, "R6 framing cleared");

        // R2 overrun
        fifo_full = 1;
        send(8'h00, 0, 1);
        fifo_full = 0;
        chk(raw_stat, 32'h400, "R2 overrun set");
        clear(11'h400);
        // R5 break
        brk_det = 1; cyc(); brk_det = 0;
        chk(raw_stat, 32'h200, "R5 break set");
        cyc(5);
        chk(raw_stat, 32'h200, "R6 break sticky");
        // R6 set beats clear
        brk_det = 1; clr_wr = 1; clr_data = 11'h200; cyc();
        brk_det = 0; clr_wr = 0; clr_data = '0;
        chk(raw_stat, 32'h200, "R6 set wins over clear");
        clear(11'h200);
        // R6 tx/rx events
        tx_evt = 1; rx_evt = 1; cyc(); tx_evt = 0; rx_evt = 0;
        chk(raw_stat, 32'h30, "R6 tx/rx set");
        clear(11'h020);
        chk(raw_stat, 32'h10, "R6 tx only cleared");
        clear(11'h010);
        chk(raw_stat, 0, "R6 all clear");

        // R4 parity sweep
        par_en = 1;
        for (int m = 0; m < 4; m++) begin
            par_stick = m[1]; par_even = m[0];
            for (int d = 0; d < 256; d++) begin
                for (int pb = 0; pb < 2; pb++) begin
                    int ones;
                    logic want;
                    ones = $countones(d[7:0]);
                    if (m[1]) want = ~m[0];
                    else if (m[0]) want = ones[0];
                    else want = ~ones[0];
                    send(d[7:0], pb[0], 1);
                    chk(raw_stat[8], (pb[0] != want), "R4 parity compare");
                    clear(11'h100);
                end
            end
        end
        par_en = 0;
        send(8'h01, 1, 1);
        send(8'h01, 0, 1);
        chk(raw_stat, 0, "R4 parity disabled");

        // R7 timeout threshold
        irq_mask = 11'h040;
        fifo_empty = 0; fifo_push = 1; cyc(); fifo_push = 0;
        bit_tick = 1; cyc(31); bit_tick = 0;
        chk(raw_stat, 0, "R7 31 ticks no timeout");
        bit_tick = 1; cyc(); bit_tick = 0;
        chk(raw_stat, 0, "R7 at 32 ticks not yet");
        cyc();
        chk(raw_stat, 32'h40, "R7 timeout raised");
        chk({masked_stat[30:0], irq}, {31'h40, 1'b1}, "R9 raw equals masked/irq");
        // R8 clear write and restart
        clear(11'h040);
        chk(raw_stat, 0, "R8 cleared by write");
        cyc(5);
        chk(raw_stat, 0, "R8 stays clear after write");
        bit_tick = 1; cyc(32); bit_tick = 0; cyc();
        chk(raw_stat, 32'h40, "R7 raised again after restart");
        // R8 empty drains
        fifo_empty = 1; cyc();
        chk(raw_stat, 0, "R8 cleared by empty");
        // R7 push restarts
        fifo_empty = 0; fifo_push = 1; cyc(); fifo_push = 0;
        bit_tick = 1; cyc(20); bit_tick = 0;
        fifo_push = 1; cyc(); fifo_push = 0;
        bit_tick = 1; cyc(20); bit_tick = 0; cyc(2);
        chk(raw_stat, 0, "R7 push restarts count");
        // R9 mask off blocks
        irq_mask = 0;
        bit_tick = 1; cyc(40); bit_tick = 0; cyc(2);
        chk(raw_stat, 0, "R9 masked off never raised");
        irq_mask = 11'h040; cyc(2);
        chk(raw_stat, 32'h40, "R9 raised once enabled");
        irq_mask = 0; #1;
        chk({raw_stat[6], masked_stat[6]}, 0, "R9 raw follows mask");
        fifo_empty = 1; cyc(2);

        // R10 mask sweep
        fifo_full = 1; send(8'h00, 0, 0); fifo_full = 0;
        brk_det = 1; tx_evt = 1; rx_evt = 1; cyc();
        brk_det = 0; tx_evt = 0; rx_evt = 0;
        par_en = 1; par_even = 1; par_stick = 0; send(8'h00, 1, 1); par_en = 0;
        chk(raw_stat, 32'h7B0, "R1 bit layout");
        for (int m = 0; m < 2048; m++) begin
            irq_mask = m[10:0];
            #1;
            chk(masked_stat, 32'h7B0 & m, "R10 masked");
            chk({31'h0, irq}, {31'h0, |(32'h7B0 & m)}, "R10 irq");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule